// File: doc/BRIEF.md
# Zero-Suppressed Token Readout Serializer

This block serializes the hits held by 64 independent channels onto a single data line that several chips share. A chip drives the line only while it holds the readout token, so the chips are read out one after another. When a token arrives, the block sends a chip identification word and then visits the channels in ascending order. Channels that hold no events are skipped. Each hit channel yields a header word, followed by one word for every event stored for that channel. When the last word has gone out, the token passes to the next chip as a single-cycle pulse.

Each word begins with a type bit (1 for identification and header words, 0 for event words), carries its payload most significant bit first, and ends with an even-parity bit. Event data comes from an external per-channel memory through a combinational read port that the block addresses. A mode input selects what an empty chip does: it either stays silent and passes the token at once, or sends only its identification word.

Top module: `zs_token_readout`

## Requirements
- R1: After reset, and whenever no readout is in progress, serValid and tokenOut are low and serOut is low.
- R2: A readout starts only on a tokenIn pulse seen while idle. A tokenIn pulse during a readout is ignored and does not add words or a second tokenOut pulse.
- R3: The first word of every readout is the identification word: bit 1, then the 7-bit chipId (MSB first), then parity, 9 bits in all.
- R4: A channel header word is bit 1, the 6-bit channel number, the 4-bit event count from evtCount[ch*4 +: 4], then parity, 12 bits in all.
- R5: After its header, a channel sends exactly count event words for event indices 0 to count-1 in order. Each is bit 0, the 14-bit memRdData read at memRdCh=channel and memRdEvt=index (12-bit timestamp above the 2-bit charge code), then parity, 16 bits in all.
- R6: Channels are visited in ascending order from 0 to 63, and a channel whose count is zero produces no words.
- R7: The final bit of every word equals the XOR of the bits between the type bit and the final bit, so that the payload and parity together hold an even number of ones.
- R8: If every count is zero and emptyIdMode is 0, no bit is sent (serValid stays low) and tokenOut still pulses once.
- R9: If every count is zero and emptyIdMode is 1, only the identification word is sent, then tokenOut pulses once.
- R10: Every readout ends with exactly one tokenOut pulse that lasts one cycle. It comes after the last valid bit, and serValid is low while and after it pulses.
- R11: serOut is low in every cycle in which serValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tokenIn | input | 1 | Readout token from the previous chip, one-cycle pulse |
| emptyIdMode | input | 1 | 1: an empty chip sends its identification word; 0: it sends nothing |
| chipId | input | 7 | Chip identifier |
| evtCount | input | 256 | Stored event count per channel, 4 bits each, channel c at bits c*4+3..c*4 |
| memRdCh | output | 6 | Event memory read address, channel |
| memRdEvt | output | 4 | Event memory read address, event index |
| memRdData | input | 14 | Event memory read data {timestamp[11:0], charge[1:0]}, combinational |
| serOut | output | 1 | Serial data, MSB first |
| serValid | output | 1 | High while serOut carries a word bit |
| tokenOut | output | 1 | Token to the next chip, one-cycle pulse |

## Verification
The bench targets the edges of the channel scan: only channel 0 hit, only channel 63 hit with a full eight events, and every channel full. A scanner that is off by one drops or repeats a channel, and a pointer that wraps at 63 loops back and sends channel 0 again. Both empty-chip modes are run, where a wrong decision emits a stray identification word or none at all. A second token is injected in the middle of a readout, which catches a design that restarts its stream or passes the token twice. Random hit patterns with random timestamps exercise the parity and the order of event indices within each channel.

// File: rtl/zs_readout_pkg.sv
package zs_readout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHIP_ID,
    ST_SCAN,
    ST_HEADER,
    ST_EVENTS,
    ST_PASS_TOKEN
  } rdoState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadId;
    logic loadHdr;
    logic loadEvt;
    logic shift;
  } rdoStrobe_t;

endpackage

// File: rtl/zs_next_hit.sv
// Finds the lowest channel at or above startPtr whose hit flag is set.
module zs_next_hit #(
  parameter int NUM_CH = 64,
  parameter int PTR_W  = 7
) (
  input  logic [NUM_CH-1:0] hitVec,
  input  logic [PTR_W-1:0]  startPtr,
  output logic              found,
  output logic [PTR_W-1:0]  foundCh
);

  logic [NUM_CH-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_elig
      assign eligible[g] = hitVec[g] && (PTR_W'(g) >= startPtr);
    end
  endgenerate

  always_comb begin
    found   = 1'b0;
    foundCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found   = 1'b1;
        foundCh = PTR_W'(i);
      end
    end
  end

endmodule

// File: rtl/zs_readout_datapath.sv
// Word assembly and MSB-first shift register.
module zs_readout_datapath
  import zs_readout_pkg::*;
#(
  parameter int CH_W  = 6,
  parameter int CNT_W = 4,
  parameter int TS_W  = 12,
  parameter int CHG_W = 2,
  parameter int ID_W  = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rdoStrobe_t            strobe,
  input  logic [ID_W-1:0]       chipId,
  input  logic [CH_W-1:0]       hdrCh,
  input  logic [CNT_W-1:0]      hdrCnt,
  input  logic [TS_W+CHG_W-1:0] evtData,
  output logic                  serOut,
  output logic                  serValid,
  output logic                  wordDone
);

  localparam int ID_LEN  = ID_W + 2;
  localparam int HDR_LEN = CH_W + CNT_W + 2;
  localparam int EVT_LEN = TS_W + CHG_W + 2;
  localparam int MAX_A   = (ID_LEN > HDR_LEN) ? ID_LEN : HDR_LEN;
  localparam int SH_W    = (MAX_A > EVT_LEN) ? MAX_A : EVT_LEN;
  localparam int LEN_W   = $clog2(SH_W + 1);

  logic [SH_W-1:0]    shReg;
  logic [LEN_W-1:0]   bitsLeft;
  logic [ID_LEN-1:0]  idWord;
  logic [HDR_LEN-1:0] hdrWord;
  logic [EVT_LEN-1:0] evtWord;

  assign idWord  = {1'b1, chipId, ^chipId};
  assign hdrWord = {1'b1, hdrCh, hdrCnt, ^{hdrCh, hdrCnt}};
  assign evtWord = {1'b0, evtData, ^evtData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
    end else if (strobe.loadId) begin
      shReg    <= SH_W'(idWord) << (SH_W - ID_LEN);
      bitsLeft <= LEN_W'(ID_LEN);
    end else if (strobe.loadHdr) begin
      shReg    <= SH_W'(hdrWord) << (SH_W - HDR_LEN);
      bitsLeft <= LEN_W'(HDR_LEN);
    end else if (strobe.loadEvt) begin
      shReg    <= SH_W'(evtWord) << (SH_W - EVT_LEN);
      bitsLeft <= LEN_W'(EVT_LEN);
    end else if (strobe.shift && (bitsLeft != '0)) begin
      shReg    <= shReg << 1;
      bitsLeft <= bitsLeft - LEN_W'(1);
    end
  end

  assign serValid = (bitsLeft != '0);
  assign serOut   = serValid & shReg[SH_W-1];
  assign wordDone = (bitsLeft == LEN_W'(1));

endmodule

// File: rtl/zs_readout_ctrl.sv
// Readout sequencing: identification word, channel scan, headers, events, token.
module zs_readout_ctrl
  import zs_readout_pkg::*;
#(
  parameter int CH_W  = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tokenIn,
  input  logic             emptyIdMode,
  input  logic             anyHit,
  input  logic             wordDone,
  input  logic             found,
  input  logic [CH_W:0]    foundCh,
  input  logic [CNT_W-1:0] curCnt,
  output rdoStrobe_t       strobe,
  output logic [CH_W:0]    scanPtr,
  output logic [CNT_W-1:0] rdEvt,
  output logic             tokenOut
);

  rdoState_e        state, nextState;
  logic [CNT_W-1:0] evtIdx;
  logic             moreEvt;

  assign moreEvt = ({1'b0, evtIdx} + (CNT_W+1)'(1)) < {1'b0, curCnt};
  assign rdEvt   = (state == ST_HEADER) ? '0 : evtIdx + CNT_W'(1);

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (tokenIn) begin
          if (anyHit || emptyIdMode) begin
            strobe.loadId = 1'b1;
            nextState     = ST_CHIP_ID;
          end else begin
            nextState = ST_PASS_TOKEN;
          end
        end
      end
      ST_CHIP_ID: begin
        strobe.shift = 1'b1;
        if (wordDone) nextState = ST_SCAN;
      end
      ST_SCAN: begin
        if (found) begin
          strobe.loadHdr = 1'b1;
          nextState      = ST_HEADER;
        end else begin
          nextState = ST_PASS_TOKEN;
        end
      end
      ST_HEADER: begin
        strobe.shift = 1'b1;
        if (wordDone) begin
          strobe.loadEvt = 1'b1;
          nextState      = ST_EVENTS;
        end
      end
      ST_EVENTS: begin
        strobe.shift = 1'b1;
        if (wordDone) begin
          if (moreEvt) strobe.loadEvt = 1'b1;
          else         nextState      = ST_SCAN;
        end
      end
      ST_PASS_TOKEN: nextState = ST_IDLE;
      default:       nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanPtr <= '0;
      evtIdx  <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && tokenIn) scanPtr <= '0;
      if (state == ST_SCAN && found)   scanPtr <= foundCh;
      if (state == ST_HEADER && wordDone) evtIdx <= '0;
      if (state == ST_EVENTS && wordDone) begin
        if (moreEvt) evtIdx  <= evtIdx + CNT_W'(1);
        else         scanPtr <= scanPtr + (CH_W+1)'(1);
      end
    end
  end

  assign tokenOut = (state == ST_PASS_TOKEN);

endmodule

// File: rtl/zs_token_readout.sv
module zs_token_readout
  import zs_readout_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int CNT_W  = 4,
  parameter int TS_W   = 12,
  parameter int CHG_W  = 2,
  parameter int ID_W   = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tokenIn,
  input  logic                         emptyIdMode,
  input  logic [ID_W-1:0]              chipId,
  input  logic [NUM_CH*CNT_W-1:0]      evtCount,
  output logic [$clog2(NUM_CH)-1:0]    memRdCh,
  output logic [CNT_W-1:0]             memRdEvt,
  input  logic [TS_W+CHG_W-1:0]        memRdData,
  output logic                         serOut,
  output logic                         serValid,
  output logic                         tokenOut
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int PTR_W = CH_W + 1;

  logic [CNT_W-1:0]  cntArr [NUM_CH];
  logic [NUM_CH-1:0] hitVec;
  logic              anyHit, found, wordDone;
  logic [PTR_W-1:0]  foundCh, scanPtr;
  logic [CNT_W-1:0]  curCnt, hdrCnt;
  rdoStrobe_t        strobe;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_cnt
      assign cntArr[g] = evtCount[g*CNT_W +: CNT_W];
      assign hitVec[g] = |cntArr[g];
    end
  endgenerate

  assign anyHit  = |hitVec;
  assign memRdCh = scanPtr[CH_W-1:0];
  assign curCnt  = cntArr[scanPtr[CH_W-1:0]];
  assign hdrCnt  = cntArr[foundCh[CH_W-1:0]];

  zs_next_hit #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_nextHit (
    .hitVec  (hitVec),
    .startPtr(scanPtr),
    .found   (found),
    .foundCh (foundCh)
  );

  zs_readout_ctrl #(.CH_W(CH_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tokenIn    (tokenIn),
    .emptyIdMode(emptyIdMode),
    .anyHit     (anyHit),
    .wordDone   (wordDone),
    .found      (found),
    .foundCh    (foundCh),
    .curCnt     (curCnt),
    .strobe     (strobe),
    .scanPtr    (scanPtr),
    .rdEvt      (memRdEvt),
    .tokenOut   (tokenOut)
  );

  zs_readout_datapath #(
    .CH_W(CH_W), .CNT_W(CNT_W), .TS_W(TS_W), .CHG_W(CHG_W), .ID_W(ID_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .chipId  (chipId),
    .hdrCh   (foundCh[CH_W-1:0]),
    .hdrCnt  (hdrCnt),
    .evtData (memRdData),
    .serOut  (serOut),
    .serValid(serValid),
    .wordDone(wordDone)
  );

endmodule

// File: rtl/zs_token_readout_checker.sv
module zs_token_readout_checker (
  input logic clk,
  input logic rstN,
  input logic tokenIn,
  input logic tokenOut,
  input logic serOut,
  input logic serValid
);

  // set by an accepted token, cleared when the token is passed on
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (tokenOut) armed <= 1'b0;
    else if (tokenIn)  armed <= 1'b1;
  end

  a_r11_line_low_when_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !serValid |-> !serOut);

  a_r10_token_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);

  a_r10_no_data_with_token: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |-> !serValid);

  a_r10_no_data_after_token: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !serValid);

  a_r2_token_out_needs_token_in: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |-> armed);

endmodule

bind zs_token_readout zs_token_readout_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tokenIn (tokenIn),
  .tokenOut(tokenOut),
  .serOut  (serOut),
  .serValid(serValid)
);

// File: tb/tb_zs_token_readout.sv
`timescale 1ns/1ps
module tb_zs_token_readout;

  localparam int NUM_CH = 64;
  localparam int CNT_W  = 4;
  localparam int TS_W   = 12;
  localparam int CHG_W  = 2;
  localparam int ID_W   = 7;
  localparam int CH_W   = 6;
  localparam int MAXEV  = 8;
  localparam int DW     = TS_W + CHG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tokenIn = 1'b0;
  logic emptyIdMode = 1'b0;
  logic [ID_W-1:0] chipId = '0;
  logic [NUM_CH*CNT_W-1:0] evtCount = '0;
  logic [CH_W-1:0] memRdCh;
  logic [CNT_W-1:0] memRdEvt;
  logic [DW-1:0] memRdData;
  logic serOut, serValid, tokenOut;

  logic [DW-1:0] memArr [NUM_CH][MAXEV];
  int cntArr [NUM_CH];

  always #4 clk = ~clk;

  always_comb memRdData = (memRdEvt < CNT_W'(MAXEV)) ? memArr[memRdCh][memRdEvt[2:0]] : '0;

  zs_token_readout dut (
    .clk(clk), .rstN(rstN), .tokenIn(tokenIn), .emptyIdMode(emptyIdMode),
    .chipId(chipId), .evtCount(evtCount), .memRdCh(memRdCh), .memRdEvt(memRdEvt),
    .memRdData(memRdData), .serOut(serOut), .serValid(serValid), .tokenOut(tokenOut)
  );

  int errors = 0;
  int checks = 0;
  bit actQ[$];
  bit expQ[$];
  int tokCnt = 0;
  int validAfterTok = 0;
  int badIdle = 0;
  bit collecting = 1'b0;
  int cycles = 0;

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!serValid && serOut) badIdle++;
    if (collecting) begin
      if (serValid) begin
        actQ.push_back(serOut);
        if (tokCnt > 0) validAfterTok++;
      end
      if (tokenOut) tokCnt++;
    end
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushBits(input logic [31:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) expQ.push_back(w[i]);
  endtask

  task automatic applyCounts();
    for (int c = 0; c < NUM_CH; c++) evtCount[c*CNT_W +: CNT_W] = CNT_W'(cntArr[c]);
  endtask

  // expected stream built from the word formats in R3..R7
  task automatic buildExp();
    bit any;
    logic [CH_W-1:0] chv;
    logic [CNT_W-1:0] cv;
    expQ.delete();
    any = 1'b0;
    for (int c = 0; c < NUM_CH; c++) if (cntArr[c] != 0) any = 1'b1;
    if (any || emptyIdMode) pushBits({23'd0, 1'b1, chipId, ^chipId}, 9);
    for (int c = 0; c < NUM_CH; c++) begin
      if (cntArr[c] != 0) begin
        chv = CH_W'(c);
        cv  = CNT_W'(cntArr[c]);
        pushBits({20'd0, 1'b1, chv, cv, ^{chv, cv}}, 12);
        for (int e = 0; e < cntArr[c]; e++)
          pushBits({16'd0, 1'b0, memArr[c][e], ^memArr[c][e]}, 16);
      end
    end
  endtask

  task automatic setRandom(input int pctHit);
    for (int c = 0; c < NUM_CH; c++) begin
      cntArr[c] = (($urandom % 100) < pctHit) ? 1 + int'($urandom % MAXEV) : 0;
      for (int e = 0; e < MAXEV; e++) memArr[c][e] = DW'($urandom);
    end
  endtask

  task automatic clearAll();
    for (int c = 0; c < NUM_CH; c++) begin
      cntArr[c] = 0;
      for (int e = 0; e < MAXEV; e++) memArr[c][e] = DW'($urandom);
    end
  endtask

  task automatic runCase(input string req, input bit busyPulse);
    int mis;
    @(negedge clk);
    applyCounts();
    buildExp();
    actQ.delete();
    tokCnt = 0;
    validAfterTok = 0;
    collecting = 1'b1;
    @(negedge clk) tokenIn = 1'b1;
    @(negedge clk) tokenIn = 1'b0;
    for (int c = 0; c < 20000 && tokCnt == 0; c++) begin
      @(negedge clk);
      tokenIn = (busyPulse && c == 15) ? 1'b1 : 1'b0;
    end
    tokenIn = 1'b0;
    repeat (40) @(negedge clk);
    collecting = 1'b0;
    check(tokCnt == 1, "R10", "tokenOut pulses per readout", tokCnt, 1);
    check(validAfterTok == 0, "R10", "valid bits after tokenOut", validAfterTok, 0);
    check(actQ.size() == expQ.size(), req, "stream length", actQ.size(), expQ.size());
    mis = -1;
    for (int i = 0; i < actQ.size() && i < expQ.size(); i++)
      if (mis < 0 && actQ[i] != expQ[i]) mis = i;
    check(mis == -1, req, "first mismatching bit index", mis, -1);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    clearAll();
    chipId = 7'h5B;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!serValid && !serOut && !tokenOut, "R1", "outputs in reset",
          {serValid, serOut, tokenOut}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!serValid && !serOut && !tokenOut, "R1", "outputs idle after reset",
          {serValid, serOut, tokenOut}, 0);

    // R8: empty chip, silent mode
    emptyIdMode = 1'b0;
    runCase("R8", 1'b0);
    // R9 and R3: empty chip, identification-only mode
    emptyIdMode = 1'b1;
    chipId = 7'h2C;
    runCase("R9 R3", 1'b0);

    // R4, R5: channel 0 only, one event
    emptyIdMode = 1'b0;
    clearAll();
    cntArr[0] = 1;
    runCase("R4 R5", 1'b0);

    // R6, R5: channel 63 only, eight events
    clearAll();
    cntArr[63] = 8;
    runCase("R6 R5", 1'b0);

    // R6: every channel full
    clearAll();
    for (int c = 0; c < NUM_CH; c++) cntArr[c] = MAXEV;
    chipId = 7'h7F;
    runCase("R6 R7", 1'b0);

    // R2: second token during a busy readout is ignored
    setRandom(30);
    cntArr[2] = 3;
    runCase("R2", 1'b1);

    // random patterns, R7 parity and R3..R6 framing
    for (int t = 0; t < 6; t++) begin
      emptyIdMode = t[0];
      chipId = ID_W'($urandom);
      setRandom(5 + 15 * t);
      runCase("R3 R4 R5 R6 R7", 1'b0);
    end

    // R11: line held low whenever not valid, over the whole run
    check(badIdle == 0, "R11", "cycles with serOut high while invalid", badIdle, 0);
    check(!serValid && !tokenOut, "R1", "idle after all readouts", {serValid, tokenOut}, 0);
    finishRun();
  end

endmodule